// File: doc/BRIEF.md
# Integer ALU with Immediate Extension

This block is the combinational integer execution stage of a small load/store RISC core. It receives a register operand, a second register operand or a 16-bit immediate, and an operation select, and returns a 32-bit result together with a signed-overflow exception flag in the same cycle.

The immediate is widened to the datapath width according to the selected operation. Signed arithmetic and all comparisons widen it with its sign bit. Unsigned arithmetic and the bitwise operations widen it with zeros. The block covers:

- add and subtract, each in a signed and an unsigned form;
- AND, OR and XOR;
- a load-high form that places the immediate in the upper half of the result;
- three shifts;
- six signed set-on-compare operations.

Instruction decode, the register file and the handling of a raised flag all sit outside this block.

Top module: `alu_exec`

## Requirements
- R1: For the add and subtract selects (signed and unsigned), the result is the sum or difference of the first operand and the second operand, taken modulo 2^32. The second operand is the register operand, or the immediate when use_imm_i is 1.
- R2: ovf_o goes to 1 for a signed add when both operands have the same sign and the result sign differs. It goes to 1 for a signed subtract when the operand signs differ and the result sign differs from the first operand.
- R3: ovf_o stays 0 for every select other than signed add and signed subtract, including the unsigned add and subtract selects.
- R4: For signed add, signed subtract and the six compare selects, the immediate is sign-extended from bit 15.
- R5: For unsigned add, unsigned subtract, AND, OR and XOR, the immediate is zero-extended.
- R6: AND, OR and XOR produce the bitwise combination of the first operand and the second operand.
- R7: The load-high select places imm_i in result bits 31..16 and zeros in bits 15..0.
- R8: The compare selects (equal, not equal, less, less-or-equal, greater, greater-or-equal) treat both operands as signed two's complement. The result is 32'h1 when the condition holds and 32'h0 when it does not.
- R9: The shift amount is the low five bits of the second operand. All higher bits are ignored.
- R10: Logical left and logical right shifts fill vacated bits with zeros. Arithmetic right shift fills them with copies of bit 31.
- R11: The no-operation select gives a zero result and a low ovf_o.
- R12: The op_i encoding is the op_e type in alu_pkg: NOP=0, ADD=1, ADDU=2, SUB=3, SUBU=4, AND=5, OR=6, XOR=7, LHI=8, SLL=9, SRL=10, SRA=11, SEQ=12, SNE=13, SLT=14, SLE=15, SGT=16, SGE=17. Values 18 to 31 behave as NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation select (alu_pkg::op_e encoding) |
| rs_a_i | input | 32 | First register operand |
| rs_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | 1 selects the extended immediate as the second operand |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed add/subtract overflow flag |

## Verification
Directed vectors sit on the sign boundaries 0x7FFFFFFF and 0x80000000. On these vectors only the overflow flag separates signed add and subtract from their unsigned twins. An immediate with bit 15 set shows whether the sign-extension rule or the zero-extension rule was applied for each select. Shift amounts with bits above bit 4 set show whether upper bits leak into the shift. A negative operand separates arithmetic from logical right shift. Compares of -1 against 1 and of equal values tell signed ordering from unsigned ordering and pin the equality edges. Random operands and selects, with both operand sources, then cover the remaining mix.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADDU = 5'd2,
    OP_SUB  = 5'd3,
    OP_SUBU = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_LHI  = 5'd8,
    OP_SLL  = 5'd9,
    OP_SRL  = 5'd10,
    OP_SRA  = 5'd11,
    OP_SEQ  = 5'd12,
    OP_SNE  = 5'd13,
    OP_SLT  = 5'd14,
    OP_SLE  = 5'd15,
    OP_SGT  = 5'd16,
    OP_SGE  = 5'd17
  } op_e;

  function automatic logic op_is_cmp(op_e op);
    return (op == OP_SEQ) || (op == OP_SNE) || (op == OP_SLT) ||
           (op == OP_SLE) || (op == OP_SGT) || (op == OP_SGE);
  endfunction

  // sign-extend immediate for signed arithmetic and compares (R4)
  function automatic logic op_sext_imm(op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || op_is_cmp(op);
  endfunction
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sext_i,
  output logic [WIDTH-1:0] ext_o
);
  localparam int PAD_W = WIDTH - IMM_W;

  logic fill;
  assign fill  = sext_i & imm_i[IMM_W-1];
  assign ext_o = {{PAD_W{fill}}, imm_i};
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};

  // same-sign inputs to the adder with a flipped result sign
  assign ovf_o = signed_i & (a_i[MSB] == b_eff[MSB]) & (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         data_i,
  input  logic [$clog2(WIDTH)-1:0] amt_i,
  input  logic                     left_i,
  input  logic                     arith_i,
  output logic [WIDTH-1:0]         data_o
);
  localparam int SH_W = $clog2(WIDTH);

  logic [WIDTH-1:0] stage [SH_W+1];
  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] rev_out;
  logic             fill;

  // left shift done as a right shift on bit-reversed data
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = data_i[WIDTH-1-i];
    assign rev_out[i] = stage[SH_W][WIDTH-1-i];
  end

  assign fill     = arith_i & ~left_i & data_i[WIDTH-1];
  assign stage[0] = left_i ? rev_in : data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{D{fill}}, stage[s][WIDTH-1:D]} : stage[s];
  end

  assign data_o = left_i ? rev_out : stage[SH_W];
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o,
  output logic             lt_o
);
  assign eq_o = (a_i == b_i);
  assign lt_o = $signed(a_i) < $signed(b_i);
endmodule

// File: rtl/alu_exec.sv
module alu_exec #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [alu_pkg::OP_W-1:0] op_i,
  input  logic [WIDTH-1:0]         rs_a_i,
  input  logic [WIDTH-1:0]         rs_b_i,
  input  logic [IMM_W-1:0]         imm_i,
  input  logic                     use_imm_i,
  output logic [WIDTH-1:0]         result_o,
  output logic                     ovf_o
);
  import alu_pkg::*;

  localparam int SH_W  = $clog2(WIDTH);
  localparam int LOW_W = WIDTH - IMM_W;

  op_e              op;
  logic [WIDTH-1:0] imm_ext;
  logic [WIDTH-1:0] opb;
  logic [WIDTH-1:0] sum;
  logic             add_ovf;
  logic             is_sub;
  logic             is_signed;
  logic [WIDTH-1:0] sh_res;
  logic             cmp_eq;
  logic             cmp_lt;
  logic             cmp_bit;

  assign op = op_e'(op_i);

  alu_imm_ext #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_imm_ext (
    .imm_i  (imm_i),
    .sext_i (op_sext_imm(op)),
    .ext_o  (imm_ext)
  );

  assign opb = use_imm_i ? imm_ext : rs_b_i;

  assign is_sub    = (op == OP_SUB) || (op == OP_SUBU);
  assign is_signed = (op == OP_ADD) || (op == OP_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i      (rs_a_i),
    .b_i      (opb),
    .sub_i    (is_sub),
    .signed_i (is_signed),
    .sum_o    (sum),
    .ovf_o    (add_ovf)
  );

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .data_i  (rs_a_i),
    .amt_i   (opb[SH_W-1:0]),
    .left_i  (op == OP_SLL),
    .arith_i (op == OP_SRA),
    .data_o  (sh_res)
  );

  alu_cmp #(.WIDTH(WIDTH)) u_cmp (
    .a_i  (rs_a_i),
    .b_i  (opb),
    .eq_o (cmp_eq),
    .lt_o (cmp_lt)
  );

  always_comb begin
    unique case (op)
      OP_SEQ:  cmp_bit = cmp_eq;
      OP_SNE:  cmp_bit = ~cmp_eq;
      OP_SLT:  cmp_bit = cmp_lt;
      OP_SLE:  cmp_bit = cmp_lt | cmp_eq;
      OP_SGT:  cmp_bit = ~(cmp_lt | cmp_eq);
      OP_SGE:  cmp_bit = ~cmp_lt;
      default: cmp_bit = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
      OP_AND:  result_o = rs_a_i & opb;
      OP_OR:   result_o = rs_a_i | opb;
      OP_XOR:  result_o = rs_a_i ^ opb;
      OP_LHI:  result_o = {imm_i, {LOW_W{1'b0}}};
      OP_SLL, OP_SRL, OP_SRA: result_o = sh_res;
      OP_SEQ, OP_SNE, OP_SLT, OP_SLE, OP_SGT, OP_SGE:
               result_o = {{(WIDTH-1){1'b0}}, cmp_bit};
      default: result_o = '0;
    endcase
  end

  assign ovf_o = add_ovf;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input logic [alu_pkg::OP_W-1:0] op_i,
  input logic [WIDTH-1:0]         rs_b_i,
  input logic [IMM_W-1:0]         imm_i,
  input logic                     use_imm_i,
  input logic [WIDTH-1:0]         result_o,
  input logic                     ovf_o
);
  import alu_pkg::*;

  localparam int SH_W  = $clog2(WIDTH);
  localparam int LOW_W = WIDTH - IMM_W;

  op_e             op;
  logic [SH_W-1:0] amt;

  assign op  = op_e'(op_i);
  assign amt = use_imm_i ? imm_i[SH_W-1:0] : rs_b_i[SH_W-1:0];

  always_comb begin
    if (ovf_o)
      a_r2_ovf_signed_only: assert (op == OP_ADD || op == OP_SUB)
        else $error("overflow raised for op %0d", op_i);
    if (op == OP_ADDU || op == OP_SUBU)
      a_r3_no_overflow: assert (!ovf_o)
        else $error("overflow on unsigned op");
    if (op == OP_LHI)
      a_r7_lhi_layout: assert (result_o[LOW_W-1:0] == '0 && result_o[WIDTH-1:LOW_W] == imm_i)
        else $error("load-high layout wrong");
    if (op_is_cmp(op))
      a_r8_cmp_boolean: assert (result_o[WIDTH-1:1] == '0)
        else $error("compare result not 0/1");
    if (op == OP_SRL && amt != '0)
      a_r10_srl_zero_fill: assert (!result_o[WIDTH-1])
        else $error("logical right shift filled with one");
    if (op == OP_NOP)
      a_r11_nop_zero: assert (result_o == '0 && !ovf_o)
        else $error("nop produced output");
  end
endmodule

bind alu_exec alu_exec_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
  .op_i      (op_i),
  .rs_b_i    (rs_b_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .result_o  (result_o),
  .ovf_o     (ovf_o)
);

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
  import alu_pkg::*;

  localparam int W  = 32;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [4:0]    op;
  logic [W-1:0]  a, b;
  logic [IW-1:0] imm;
  logic          use_imm;
  logic [W-1:0]  res;
  logic          ovf;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  alu_exec #(.WIDTH(W), .IMM_W(IW)) u_dut (
    .op_i(op), .rs_a_i(a), .rs_b_i(b), .imm_i(imm), .use_imm_i(use_imm),
    .result_o(res), .ovf_o(ovf)
  );

  function automatic void ref_alu(input logic [4:0] o, input logic [W-1:0] x,
                                  input logic [W-1:0] y, input logic [IW-1:0] im,
                                  input logic ui, output logic [W-1:0] r,
                                  output logic v);
    logic [W-1:0] sb;
    logic [W:0]   wide;
    int           sh;
    if (o == OP_ADD || o == OP_SUB || (o >= OP_SEQ && o <= OP_SGE))
      sb = ui ? {{(W-IW){im[IW-1]}}, im} : y;
    else
      sb = ui ? {{(W-IW){1'b0}}, im} : y;
    sh = int'(sb[4:0]);
    v = 1'b0;
    case (o)
      OP_ADD:  begin wide = {x[W-1], x} + {sb[W-1], sb}; r = wide[W-1:0]; v = wide[W] != wide[W-1]; end
      OP_SUB:  begin wide = {x[W-1], x} - {sb[W-1], sb}; r = wide[W-1:0]; v = wide[W] != wide[W-1]; end
      OP_ADDU: r = x + sb;
      OP_SUBU: r = x - sb;
      OP_AND:  r = x & sb;
      OP_OR:   r = x | sb;
      OP_XOR:  r = x ^ sb;
      OP_LHI:  r = {im, 16'h0000};
      OP_SLL:  r = x << sh;
      OP_SRL:  r = x >> sh;
      OP_SRA:  r = $unsigned($signed(x) >>> sh);
      OP_SEQ:  r = {31'd0, x == sb};
      OP_SNE:  r = {31'd0, x != sb};
      OP_SLT:  r = {31'd0, $signed(x) < $signed(sb)};
      OP_SLE:  r = {31'd0, $signed(x) <= $signed(sb)};
      OP_SGT:  r = {31'd0, $signed(x) > $signed(sb)};
      OP_SGE:  r = {31'd0, $signed(x) >= $signed(sb)};
      default: r = '0;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] o);
    if (o >= OP_ADD && o <= OP_SUBU) return "R1";
    if (o >= OP_AND && o <= OP_XOR)  return "R6";
    if (o == OP_LHI)                 return "R7";
    if (o >= OP_SLL && o <= OP_SRA)  return "R10";
    if (o >= OP_SEQ && o <= OP_SGE)  return "R8";
    return "R11";
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b actual=%h expected=%h",
               req, op, a, b, imm, use_imm, act, exp);
    end
  endtask

  // drive after posedge, sample at the following negedge
  task automatic apply(input logic [4:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [IW-1:0] im, input logic ui);
    @(posedge clk);
    op = o; a = x; b = y; imm = im; use_imm = ui;
    @(negedge clk);
  endtask

  task automatic run_ref(input string rq, input string rv);
    logic [W-1:0] er;
    logic         ev;
    ref_alu(op, a, b, imm, use_imm, er, ev);
    check(rq, res, er);
    check(rv, {31'd0, ovf}, {31'd0, ev});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    op = OP_NOP; a = '0; b = '0; imm = '0; use_imm = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset/idle state: R11
    check("R11", res, '0);
    check("R11", {31'd0, ovf}, '0);

    // R2/R3 overflow boundaries
    apply(OP_ADD, 32'h7FFF_FFFF, 32'h1, '0, 1'b0);
    check("R2", {31'd0, ovf}, 32'd1); check("R1", res, 32'h8000_0000);
    apply(OP_ADDU, 32'h7FFF_FFFF, 32'h1, '0, 1'b0);
    check("R3", {31'd0, ovf}, 32'd0); check("R1", res, 32'h8000_0000);
    apply(OP_SUB, 32'h8000_0000, 32'h1, '0, 1'b0);
    check("R2", {31'd0, ovf}, 32'd1); check("R1", res, 32'h7FFF_FFFF);
    apply(OP_SUB, 32'h8000_0000, 32'hFFFF_FFFF, '0, 1'b0);
    check("R2", {31'd0, ovf}, 32'd0);
    apply(OP_SUBU, 32'h8000_0000, 32'h1, '0, 1'b0);
    check("R3", {31'd0, ovf}, 32'd0);
    apply(OP_ADD, 32'h8000_0000, 32'h8000_0000, '0, 1'b0);
    check("R2", {31'd0, ovf}, 32'd1); check("R1", res, 32'h0);

    // R4/R5 immediate extension
    apply(OP_ADD, 32'h0001_0000, '0, 16'h8000, 1'b1);
    check("R4", res, 32'h0000_8000);
    apply(OP_ADDU, 32'h0001_0000, '0, 16'h8000, 1'b1);
    check("R5", res, 32'h0001_8000);
    apply(OP_SUB, 32'h0, '0, 16'hFFFF, 1'b1);
    check("R4", res, 32'h1);
    apply(OP_OR, 32'h0, '0, 16'hF00F, 1'b1);
    check("R5", res, 32'h0000_F00F);
    apply(OP_SLT, 32'hFFFF_FFFE, '0, 16'hFFFF, 1'b1);
    check("R4", res, 32'h1);

    // R7
    apply(OP_LHI, 32'hDEAD_BEEF, 32'h1234_5678, 16'hA5C3, 1'b1);
    check("R7", res, 32'hA5C3_0000);

    // R8 signed ordering and equality edges
    apply(OP_SLT, 32'hFFFF_FFFF, 32'h1, '0, 1'b0); check("R8", res, 32'h1);
    apply(OP_SGT, 32'hFFFF_FFFF, 32'h1, '0, 1'b0); check("R8", res, 32'h0);
    apply(OP_SLE, 32'h5, 32'h5, '0, 1'b0);         check("R8", res, 32'h1);
    apply(OP_SGE, 32'h5, 32'h5, '0, 1'b0);         check("R8", res, 32'h1);
    apply(OP_SNE, 32'h5, 32'h5, '0, 1'b0);         check("R8", res, 32'h0);
    apply(OP_SEQ, 32'h5, 32'h5, '0, 1'b0);         check("R8", res, 32'h1);

    // R9 upper shift bits ignored
    apply(OP_SLL, 32'h1, 32'hFFFF_FFE3, '0, 1'b0); check("R9", res, 32'h8);
    apply(OP_SRL, 32'h8000_0000, '0, 16'hFFE4, 1'b1); check("R9", res, 32'h0800_0000);

    // R10 fill
    apply(OP_SRA, 32'h8000_0000, 32'd31, '0, 1'b0); check("R10", res, 32'hFFFF_FFFF);
    apply(OP_SRL, 32'h8000_0000, 32'd31, '0, 1'b0); check("R10", res, 32'h1);
    apply(OP_SLL, 32'hFFFF_FFFF, 32'd4, '0, 1'b0);  check("R10", res, 32'hFFFF_FFF0);

    // R11 / R12 unused codes
    apply(OP_NOP, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1);
    check("R11", res, '0); check("R11", {31'd0, ovf}, '0);
    apply(5'd25, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 1'b0);
    check("R12", res, '0); check("R12", {31'd0, ovf}, '0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] ro;
      ro = 5'($urandom % 18);
      apply(ro, $urandom, (i % 4 == 0) ? 32'($urandom % 40) : $urandom,
            16'($urandom), 1'($urandom));
      run_ref(req_of(ro), (ro == OP_ADD || ro == OP_SUB) ? "R2" : "R3");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule